// File: doc/BRIEF.md
# Query and Identifier Response Lane Replicator

This block sits on the read path of an emulated parallel NOR flash bank built from several identical devices placed side by side. While the bank is in query mode or identifier mode, a read returns what each device would answer, not array data. The block takes the byte address and access width of a read and turns the address into a per-device table index. It reads one response byte per lookup through a read-only port that the surrounding logic serves, then builds the data word the whole bank would put on the bus.

The index comes from the byte address scaled by the bank width and by the ratio of a device's maximum width to the width it is wired at. A device wider than one byte that is wired at one byte repeats its query byte across its full native width. The per-device answer is then copied into every device slice of the bank. An access wider than the bank is put together from several lookups, one per bank-width chunk. All configuration inputs are log2 byte counts and are held static while requests are in flight. A request is accepted in one cycle and its response appears two clock edges later.

Top module: `qry_lane_replicator`

## Requirements
- R1: After reset `rspValid` is 0 and `rspData` is all zeros.
- R2: A request sampled with `reqValid` high yields `rspValid` high after exactly the second following rising edge. In every other cycle `rspValid` is 0.
- R3: Widths are log2 byte counts (0 = 1 byte, 1 = 2, 2 = 4) and `reqQuery` = 1 selects query mode. The lookup index is the address shifted right by bank log2 + maximum-device log2 − device log2, and the table byte at that index is returned.
- R4: In query mode, an index of `TBL_DEPTH` (82) or more yields zero for that lookup.
- R5: In query mode with device width equal to maximum device width, the table byte sits in the lowest byte of each device-width slice of the bank, and the other bytes of the slice are zero.
- R6: In query mode with device width 1 and a larger maximum width, the table byte appears in every byte lane of the bank.
- R7: In query mode with device width below maximum width and not equal to 1, every byte of the response is zero.
- R8: When the access is wider than the bank, lookup k uses address + k·bank·bank and fills bytes k·bank through k·bank + bank − 1.
- R9: Response bytes at positions at or beyond the access width are zero.
- R10: In identifier mode, an index whose low 8 bits are 0 returns `mfrCode` and one whose low 8 bits are 1 returns `devCode`. Each code is zero-extended or truncated to the device width and copied into every device slice. Any other low byte, including 2 and 3, returns zero, and no table-size limit applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Read request strobe |
| reqAddr | input | ADDR_W | Byte address of the read |
| reqWidthLog2 | input | 2 | log2 of access width in bytes |
| reqQuery | input | 1 | 1 = query mode, 0 = identifier mode |
| cfgBankLog2 | input | 2 | log2 of bank width in bytes |
| cfgDevLog2 | input | 2 | log2 of device width as wired |
| cfgMaxDevLog2 | input | 2 | log2 of device native maximum width |
| mfrCode | input | CODE_W | Manufacturer code for identifier mode |
| devCode | input | CODE_W | Device code for identifier mode |
| tblIdx | output | 4·IDX_W | Table index per lookup, lookup k in slice k |
| tblByte | input | 32 | Table byte per lookup, served combinationally from tblIdx |
| rspValid | output | 1 | Response strobe |
| rspData | output | 32 | Assembled response word |

## Verification
A wrong shift amount or lane offset in the request stage sends a wrong index out on `tblIdx`. The response returns another entry's byte two edges later, and this shows up at once because the bench table holds a distinct value at each index. A fault in the lane selection shows up as misplaced zeros or duplicated bytes, and one in the width mask as nonzero bytes above the access width, both in the same response. Sweeping every legal mix of bank, device and maximum width, every access width, both modes, and indices at, inside and past the table edge gives each such fault a response where it differs from the expected word.

// File: rtl/qr_pkg.sv
package qr_pkg;
  localparam int LANE_CNT = 4;
  localparam int LOG_W = 2;

  typedef struct packed {
    logic                valid;
    logic                query;
    logic                repeatX8;
    logic [LOG_W-1:0]    widthLog2;
    logic [LOG_W-1:0]    bankLog2;
    logic [LOG_W-1:0]    devLog2;
    logic [LANE_CNT-1:0] useTable;
    logic [LANE_CNT-1:0] useMfr;
    logic [LANE_CNT-1:0] useDev;
  } qr_strobe_t;
endpackage

// File: rtl/qr_ctrl.sv
module qr_ctrl
  import qr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TBL_DEPTH = 82,
  parameter int IDX_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LOG_W-1:0]          reqWidthLog2,
  input  logic                      reqQuery,
  input  logic [LOG_W-1:0]          cfgBankLog2,
  input  logic [LOG_W-1:0]          cfgDevLog2,
  input  logic [LOG_W-1:0]          cfgMaxDevLog2,
  output logic [LANE_CNT*IDX_W-1:0] tblIdx,
  output qr_strobe_t                strobe
);
  localparam int CNT_W = LOG_W + 2;

  logic              sValid;
  logic [ADDR_W-1:0] sAddr;
  logic [LOG_W-1:0]  sWidth;
  logic              sQuery;

  always_ff @(posedge clk) begin
    if (rst) begin
      sValid <= 1'b0;
      sAddr  <= '0;
      sWidth <= '0;
      sQuery <= 1'b0;
    end else begin
      sValid <= reqValid;
      if (reqValid) begin
        sAddr  <= reqAddr;
        sWidth <= reqWidthLog2;
        sQuery <= reqQuery;
      end
    end
  end

  logic [LOG_W:0] shiftAmt;
  logic           narrowMode;
  logic           supported;

  assign shiftAmt   = {1'b0, cfgBankLog2} + {1'b0, cfgMaxDevLog2} - {1'b0, cfgDevLog2};
  assign narrowMode = cfgDevLog2 != cfgMaxDevLog2;
  assign supported  = !narrowMode || (cfgDevLog2 == '0);

  logic [LANE_CNT-1:0] useTableV, useMfrV, useDevV;

  for (genvar k = 0; k < LANE_CNT; k++) begin : g_lookup
    logic [ADDR_W-1:0] laneAddr;
    logic [ADDR_W-1:0] idxFull;
    logic              active;
    logic              inRange;

    assign laneAddr = sAddr + (ADDR_W'(k) << ({1'b0, cfgBankLog2} << 1));
    assign idxFull  = laneAddr >> shiftAmt;
    assign active   = (CNT_W'(k) << cfgBankLog2) < (CNT_W'(1) << sWidth);
    assign inRange  = idxFull < ADDR_W'(TBL_DEPTH);

    assign useTableV[k] = sValid && active && sQuery && supported && inRange;
    assign useMfrV[k]   = sValid && active && !sQuery && (idxFull[7:0] == 8'd0);
    assign useDevV[k]   = sValid && active && !sQuery && (idxFull[7:0] == 8'd1);
    assign tblIdx[k*IDX_W +: IDX_W] = inRange ? idxFull[IDX_W-1:0] : '0;

    assert_idx_in_table_R4: assert property (@(posedge clk) disable iff (rst)
      useTableV[k] |-> (tblIdx[k*IDX_W +: IDX_W] < IDX_W'(TBL_DEPTH)));
  end

  always_comb begin
    strobe           = '0;
    strobe.valid     = sValid;
    strobe.query     = sQuery;
    strobe.repeatX8  = narrowMode;
    strobe.widthLog2 = sWidth;
    strobe.bankLog2  = cfgBankLog2;
    strobe.devLog2   = cfgDevLog2;
    strobe.useTable  = useTableV;
    strobe.useMfr    = useMfrV;
    strobe.useDev    = useDevV;
  end

  assert_stage_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> strobe.valid);

  assert_bad_combo_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.query && (cfgDevLog2 != cfgMaxDevLog2) && (cfgDevLog2 != '0))
      |-> (strobe.useTable == '0));
endmodule

// File: rtl/qr_datapath.sv
module qr_datapath
  import qr_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  qr_strobe_t            strobe,
  input  logic [LANE_CNT*8-1:0] tblByte,
  input  logic [CODE_W-1:0]     mfrCode,
  input  logic [CODE_W-1:0]     devCode,
  output logic                  rspValid,
  output logic [LANE_CNT*8-1:0] rspData
);
  localparam int DATA_W = LANE_CNT * 8;
  localparam int SEL_W = $clog2(LANE_CNT);

  logic [DATA_W-1:0] devWord [LANE_CNT];

  for (genvar k = 0; k < LANE_CNT; k++) begin : g_word
    always_comb begin
      if (strobe.useTable[k]) begin
        if (strobe.repeatX8) devWord[k] = {LANE_CNT{tblByte[k*8 +: 8]}};
        else                 devWord[k] = DATA_W'(tblByte[k*8 +: 8]);
      end else if (strobe.useMfr[k]) begin
        devWord[k] = DATA_W'(mfrCode);
      end else if (strobe.useDev[k]) begin
        devWord[k] = DATA_W'(devCode);
      end else begin
        devWord[k] = '0;
      end
    end
  end

  logic [DATA_W-1:0] assembled;

  always_comb begin
    assembled = '0;
    for (int p = 0; p < LANE_CNT; p++) begin
      logic [SEL_W-1:0] lookupSel;
      logic [SEL_W-1:0] byteSel;
      lookupSel = SEL_W'(p >> strobe.bankLog2);
      byteSel   = SEL_W'(p) & SEL_W'((1 << strobe.devLog2) - 1);
      if (p < (1 << strobe.widthLog2))
        assembled[p*8 +: 8] = devWord[lookupSel][{byteSel, 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.valid;
      rspData  <= strobe.valid ? assembled : '0;
    end
  end

  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.valid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe.valid |=> !rspValid);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.valid |=> ((rspData >> (8 << $past(strobe.widthLog2))) == '0));

  assert_x8_repeat_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.valid && strobe.repeatX8 && strobe.useTable[0] &&
     (strobe.bankLog2 != '0) && (strobe.widthLog2 != '0))
      |=> (rspData[15:8] == rspData[7:0]));
endmodule

// File: rtl/qry_lane_replicator.sv
module qry_lane_replicator
  import qr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TBL_DEPTH = 82,
  parameter int CODE_W = 16,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqWidthLog2,
  input  logic                      reqQuery,
  input  logic [1:0]                cfgBankLog2,
  input  logic [1:0]                cfgDevLog2,
  input  logic [1:0]                cfgMaxDevLog2,
  input  logic [CODE_W-1:0]         mfrCode,
  input  logic [CODE_W-1:0]         devCode,
  output logic [4*IDX_W-1:0]        tblIdx,
  input  logic [31:0]               tblByte,
  output logic                      rspValid,
  output logic [31:0]               rspData
);
  qr_strobe_t strobe;

  qr_ctrl #(
    .ADDR_W(ADDR_W),
    .TBL_DEPTH(TBL_DEPTH),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .reqValid(reqValid),
    .reqAddr(reqAddr),
    .reqWidthLog2(reqWidthLog2),
    .reqQuery(reqQuery),
    .cfgBankLog2(cfgBankLog2),
    .cfgDevLog2(cfgDevLog2),
    .cfgMaxDevLog2(cfgMaxDevLog2),
    .tblIdx(tblIdx),
    .strobe(strobe)
  );

  qr_datapath #(
    .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .tblByte(tblByte),
    .mfrCode(mfrCode),
    .devCode(devCode),
    .rspValid(rspValid),
    .rspData(rspData)
  );
endmodule

// File: tb/sim_qry_lane_replicator.sv
module sim_qry_lane_replicator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqWidthLog2 = '0;
  logic        reqQuery = 1'b0;
  logic [1:0]  cfgBankLog2 = '0;
  logic [1:0]  cfgDevLog2 = '0;
  logic [1:0]  cfgMaxDevLog2 = '0;
  logic [15:0] mfrCode = 16'h1C89;
  logic [15:0] devCode = 16'h22F7;
  logic [27:0] tblIdx;
  logic [31:0] tblByte;
  logic        rspValid;
  logic [31:0] rspData;

  int checkCnt = 0;
  int failCnt = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  qry_lane_replicator u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWidthLog2(reqWidthLog2), .reqQuery(reqQuery),
    .cfgBankLog2(cfgBankLog2), .cfgDevLog2(cfgDevLog2),
    .cfgMaxDevLog2(cfgMaxDevLog2), .mfrCode(mfrCode), .devCode(devCode),
    .tblIdx(tblIdx), .tblByte(tblByte), .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [7:0] tblVal(int i);
    return 8'((i * 29 + 19) & 255);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) tblByte[k*8 +: 8] = tblVal(int'(tblIdx[k*7 +: 7]));
  end

  function automatic logic [31:0] expResp(int addr, int w, int b, int d, int m, bit q);
    logic [31:0] r = '0;
    int bw = 1 << b;
    int dw = 1 << d;
    for (int p = 0; p < (1 << w); p++) begin
      int k = p / bw;
      int a = addr + k * bw * bw;
      int idx = a >> (b + m - d);
      int pos = p % dw;
      logic [7:0] v = 8'h00;
      if (q) begin
        if (d != m && d != 0) v = 8'h00;
        else if (idx >= 82) v = 8'h00;
        else if (d != m) v = tblVal(idx);
        else v = (pos == 0) ? tblVal(idx) : 8'h00;
      end else begin
        logic [31:0] code = '0;
        if ((idx & 255) == 0) code = {16'h0, mfrCode};
        else if ((idx & 255) == 1) code = {16'h0, devCode};
        v = code[pos*8 +: 8];
      end
      r[p*8 +: 8] = v;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  initial begin
    int idxList [10] = '{0, 1, 2, 3, 16, 39, 80, 81, 82, 256};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", {31'b0, rspValid}, 32'h0);
    check("R1 data", rspData, 32'h0);

    for (int b = 0; b <= 2; b++)
      for (int d = 0; d <= b; d++)
        for (int m = d; m <= 2; m++)
          for (int w = 0; w <= 2; w++)
            for (int qi = 0; qi <= 1; qi++)
              for (int ai = 0; ai < 10; ai++) begin
                int s = b + m - d;
                int addr = (idxList[ai] << s) | (ai & ((1 << s) - 1));
                bit q = qi[0];
                logic [31:0] exp;
                string tag;
                int idx0 = addr >> s;
                @(negedge clk);
                cfgBankLog2 = 2'(b); cfgDevLog2 = 2'(d); cfgMaxDevLog2 = 2'(m);
                reqAddr = 16'(addr); reqWidthLog2 = 2'(w); reqQuery = q;
                reqValid = 1'b1;
                @(negedge clk);
                reqValid = 1'b0;
                check("R2 early", {31'b0, rspValid}, 32'h0);
                @(negedge clk);
                check("R2 valid", {31'b0, rspValid}, 32'h1);
                exp = expResp(addr, w, b, d, m, q);
                if (!q) tag = "R10";
                else if (d != m && d != 0) tag = "R7";
                else if (idx0 >= 82) tag = "R4";
                else if (w > b) tag = "R8";
                else if (w < b) tag = "R9";
                else if (d != m) tag = "R6";
                else if (d > 0) tag = "R5";
                else tag = "R3";
                check(tag, rspData, exp);
                @(negedge clk);
                check("R2 idle", {31'b0, rspValid}, 32'h0);
              end
    finishRun();
  end
endmodule